// File: doc/BRIEF.md
# DSP Accumulator Multiply and Round Unit

This unit is a single-cycle datapath around one 64-bit accumulator. A caller presents a strobe with a 4-bit operation code, two 32-bit operands and a small shift amount. One clock later the unit raises `done` for exactly one cycle and shows a 32-bit result.

The operations fall into four groups:
- Signed 16x16 multiplies that take either the upper or the lower halves of both operands. Each multiply either overwrites the accumulator or adds to it.
- Reads of three 32-bit windows of the accumulator.
- Word loads into the upper or lower half of the accumulator.
- A round-and-saturate step that reduces the accumulator to a rounded 32-bit value held in its upper word.

Operand fetch, register files and instruction decode belong to the surrounding pipeline.

Top module: `dsp_acc_unit`

## Requirements
- R1: After synchronous reset the accumulator is zero, `result` is zero and `done` is low.
- R2: Each cycle with `start` high makes `done` high in exactly the next cycle, with `result` valid in that cycle. A cycle without `start` leaves `done` low in the next cycle.
- R3: Code 0 (multiply-high) stores the signed product of `opnd_a[31:16]` and `opnd_b[31:16]` into the accumulator, sign-extended to 64 bits. The result is the new accumulator bits 63:32.
- R4: Code 1 (multiply-low) does the same with bits 15:0 of both operands.
- R5: Codes 2 (MAC-high) and 3 (MAC-low) add the matching sign-extended product to the accumulator, modulo 2^64. The result is the new bits 63:32.
- R6: Codes 4, 5 and 6 return accumulator bits 63:32, 47:16 and 31:0 respectively, and leave the accumulator unchanged.
- R7: Code 7 writes `opnd_a` into accumulator bits 63:32. Code 8 writes it into bits 31:0. The other half is kept, and the result is the new bits 63:32.
- R8: Code 9 (round) shifts the accumulator left by `shamt` (bits shifted out are lost) and adds 0x80000000. Without saturation it then clears bits 31:0. The result is the new bits 63:32.
- R9: In the round step, a signed sum above 0x00007FFF00000000 becomes exactly that value, and a signed sum below 0xFFFF800000000000 becomes exactly that value.
- R10: A `shamt` of 1 or 2 is used as given. Any other `shamt` value rounds exactly as a shift of 1.
- R11: Codes 10 to 15 leave the accumulator unchanged, return a result of zero and still pulse `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe |
| opcode | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | First operand; also load data |
| opnd_b | input | 32 | Second operand |
| shamt | input | 2 | Round shift amount |
| result | output | 32 | Operation result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The multiplies use operand pairs whose selected halves are positive, negative and -32768. These patterns show whether the right half was picked and whether the product is sign-extended. Accumulating chains then cross zero, so a carry into the upper word is visible through the middle and low read windows. Rounding is tried on values that do not saturate, on a sum exactly equal to the upper bound (kept, not clamped), and just above it. It is also tried below the lower bound and with every `shamt` code, which separates the two accepted shifts from the default.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;

    typedef enum logic [3:0] {
        OP_MUL_HI = 4'd0,
        OP_MUL_LO = 4'd1,
        OP_MAC_HI = 4'd2,
        OP_MAC_LO = 4'd3,
        OP_RD_HI  = 4'd4,
        OP_RD_MID = 4'd5,
        OP_RD_LO  = 4'd6,
        OP_LD_HI  = 4'd7,
        OP_LD_LO  = 4'd8,
        OP_ROUND  = 4'd9
    } acc_op_e;

    typedef enum logic [1:0] {
        SL_HI  = 2'd0,
        SL_MID = 2'd1,
        SL_LO  = 2'd2
    } slice_e;

    typedef struct packed {
        logic   known;
        logic   mul;
        logic   use_hi;
        logic   accum;
        logic   rd;
        slice_e rd_sel;
        logic   ld_hi;
        logic   ld_lo;
        logic   rnd;
    } acc_ctl_t;

    function automatic acc_ctl_t decode_op(input logic [3:0] code);
        acc_ctl_t c;
        c = '0;
        c.rd_sel = SL_HI;
        c.known = 1'b1;
        case (code)
            OP_MUL_HI: begin c.mul = 1'b1; c.use_hi = 1'b1; end
            OP_MUL_LO: begin c.mul = 1'b1; end
            OP_MAC_HI: begin c.mul = 1'b1; c.use_hi = 1'b1; c.accum = 1'b1; end
            OP_MAC_LO: begin c.mul = 1'b1; c.accum = 1'b1; end
            OP_RD_HI:  begin c.rd = 1'b1; c.rd_sel = SL_HI; end
            OP_RD_MID: begin c.rd = 1'b1; c.rd_sel = SL_MID; end
            OP_RD_LO:  begin c.rd = 1'b1; c.rd_sel = SL_LO; end
            OP_LD_HI:  c.ld_hi = 1'b1;
            OP_LD_LO:  c.ld_lo = 1'b1;
            OP_ROUND:  c.rnd = 1'b1;
            default:   c.known = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dsp_half_mult.sv
module dsp_half_mult #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                use_hi,
    output logic [2*DATA_W-1:0] prod
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W;

    logic [DATA_W-1:0] part [2];

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic signed [HALF_W-1:0] ha, hb;
        logic signed [DATA_W-1:0] p;
        always_comb begin
            ha = a[g*HALF_W +: HALF_W];
            hb = b[g*HALF_W +: HALF_W];
            p  = DATA_W'(ha) * DATA_W'(hb);
        end
        assign part[g] = p;
    end

    logic [DATA_W-1:0] sel;
    assign sel  = use_hi ? part[1] : part[0];
    assign prod = {{(ACC_W-DATA_W){sel[DATA_W-1]}}, sel};

endmodule

// File: rtl/dsp_round_sat.sv
module dsp_round_sat #(
    parameter int DATA_W = 32,
    parameter int SH_W   = 2
) (
    input  logic [2*DATA_W-1:0] acc_in,
    input  logic [SH_W-1:0]     shamt,
    output logic [2*DATA_W-1:0] acc_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W;
    localparam logic [ACC_W-1:0] RND_K  = ACC_W'(1) << (DATA_W - 1);
    localparam logic [ACC_W-1:0] SAT_HI =
        {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}, {DATA_W{1'b0}}};
    localparam logic [ACC_W-1:0] SAT_LO =
        {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}, {DATA_W{1'b0}}};

    logic [SH_W-1:0]  eff_sh;
    logic [ACC_W-1:0] shifted, summed;

    always_comb begin
        if (shamt == SH_W'(1) || shamt == SH_W'(2))
            eff_sh = shamt;
        else
            eff_sh = SH_W'(1);
        shifted = acc_in << eff_sh;
        summed  = shifted + RND_K;
        if ($signed(summed) > $signed(SAT_HI))
            acc_out = SAT_HI;
        else if ($signed(summed) < $signed(SAT_LO))
            acc_out = SAT_LO;
        else
            acc_out = {summed[ACC_W-1:DATA_W], {DATA_W{1'b0}}};
    end

endmodule

// File: rtl/dsp_slice_sel.sv
module dsp_slice_sel
    import dsp_acc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] acc,
    input  slice_e              sel,
    output logic [DATA_W-1:0]   slice
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        case (sel)
            SL_HI:   slice = acc[2*DATA_W-1:DATA_W];
            SL_MID:  slice = acc[DATA_W+HALF_W-1:HALF_W];
            default: slice = acc[DATA_W-1:0];
        endcase
    end

endmodule

// File: rtl/dsp_acc_unit.sv
module dsp_acc_unit
    import dsp_acc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W;

    acc_ctl_t          ctl;
    logic [ACC_W-1:0]  acc_q, acc_d, prod, rnd_val;
    logic [DATA_W-1:0] rd_val, res_d;

    assign ctl = decode_op(opcode);

    dsp_half_mult #(.DATA_W(DATA_W)) u_mult (
        .a(opnd_a), .b(opnd_b), .use_hi(ctl.use_hi), .prod(prod)
    );

    dsp_round_sat #(.DATA_W(DATA_W), .SH_W(SH_W)) u_round (
        .acc_in(acc_q), .shamt(shamt), .acc_out(rnd_val)
    );

    dsp_slice_sel #(.DATA_W(DATA_W)) u_slice (
        .acc(acc_q), .sel(ctl.rd_sel), .slice(rd_val)
    );

    always_comb begin
        acc_d = acc_q;
        if (ctl.mul)
            acc_d = ctl.accum ? (acc_q + prod) : prod;
        else if (ctl.ld_hi)
            acc_d = {opnd_a, acc_q[DATA_W-1:0]};
        else if (ctl.ld_lo)
            acc_d = {acc_q[ACC_W-1:DATA_W], opnd_a};
        else if (ctl.rnd)
            acc_d = rnd_val;

        if (!ctl.known)
            res_d = '0;
        else if (ctl.rd)
            res_d = rd_val;
        else
            res_d = acc_d[ACC_W-1:DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                acc_q  <= acc_d;
                result <= res_d;
            end
        end
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    p_done_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    p_read_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
        (start && (opcode == OP_RD_HI || opcode == OP_RD_MID || opcode == OP_RD_LO))
        |=> $stable(acc_q));

    p_round_low_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == OP_ROUND) |=> (acc_q[DATA_W-1:0] == '0));

    p_round_bounds_r9: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == OP_ROUND) |=>
        ($signed(acc_q[ACC_W-1:DATA_W]) <= $signed(DATA_W'((1 << (HALF_W-1)) - 1)) &&
         $signed(acc_q[ACC_W-1:DATA_W]) >= -$signed(DATA_W'(1 << (HALF_W-1)))));

    p_unknown_keeps_acc_r11: assert property (@(posedge clk) disable iff (rst)
        (start && opcode > OP_ROUND) |=> ($stable(acc_q) && result == '0));

endmodule

// File: tb/dsp_acc_unit_tb_top.sv
module dsp_acc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [1:0]  shamt = '0;
    logic [31:0] result;
    logic        done;

    int total = 0;
    int bad = 0;
    logic [63:0] m_acc = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_acc_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
        .result(result), .done(done)
    );

    function automatic logic [63:0] sx16(input logic [15:0] x, input logic [15:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return 64'(p);
    endfunction

    function automatic logic [63:0] round_model(input logic [63:0] acc, input logic [1:0] s);
        longint v;
        int k;
        k = (s == 2'd2) ? 2 : 1;
        v = longint'(acc << k) + 64'h0000_0000_8000_0000;
        if (v > 64'sh0000_7FFF_0000_0000) return 64'h0000_7FFF_0000_0000;
        if (v < 64'shFFFF_8000_0000_0000) return 64'hFFFF_8000_0000_0000;
        return {v[63:32], 32'h0};
    endfunction

    task automatic issue(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [1:0] s, input string tag);
        logic [31:0] e;
        @(negedge clk);
        case (op)
            4'd0: m_acc = sx16(a[31:16], b[31:16]);
            4'd1: m_acc = sx16(a[15:0], b[15:0]);
            4'd2: m_acc = m_acc + sx16(a[31:16], b[31:16]);
            4'd3: m_acc = m_acc + sx16(a[15:0], b[15:0]);
            4'd7: m_acc = {a, m_acc[31:0]};
            4'd8: m_acc = {m_acc[63:32], a};
            4'd9: m_acc = round_model(m_acc, s);
            default: ;
        endcase
        case (op)
            4'd4: e = m_acc[63:32];
            4'd5: e = m_acc[47:16];
            4'd6: e = m_acc[31:0];
            4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: e = 32'h0;
            default: e = m_acc[63:32];
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        start = 1'b1; opcode = op; opnd_a = a; opnd_b = b; shamt = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished && done) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2: done with no pending op, result=%h expected no done", result);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (result !== e) begin
                    bad++;
                    $display("FAIL %s: result=%h expected=%h", t, result, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (done !== 1'b0 || result !== 32'h0) begin
            bad++;
            $display("FAIL R1: done=%b result=%h expected done=0 result=0", done, result);
        end
        issue(4'd4, 0, 0, 0, "R1 reset hi");
        issue(4'd6, 0, 0, 0, "R1 reset lo");
        idle(2);
        // R3 multiply-high, negative times positive
        issue(4'd0, 32'hFFFE_1234, 32'h0003_5678, 0, "R3 mul hi");
        issue(4'd6, 0, 0, 0, "R3 low word");
        issue(4'd5, 0, 0, 0, "R6 mid read");
        idle(1);
        // R4 multiply-low, -32768 squared
        issue(4'd1, 32'h1234_8000, 32'h9999_8000, 0, "R4 mul lo");
        issue(4'd6, 0, 0, 0, "R4 low word");
        issue(4'd1, 32'h7FFF_0005, 32'h8000_FFFD, 0, "R4 mul lo neg");
        issue(4'd4, 0, 0, 0, "R6 hi read");
        // R5 accumulate chains across zero
        issue(4'd2, 32'h0007_0000, 32'h0002_0000, 0, "R5 mac hi");
        issue(4'd3, 32'h0000_8000, 32'h0000_7FFF, 0, "R5 mac lo");
        issue(4'd6, 0, 0, 0, "R5 low word");
        for (int i = 0; i < 6; i++)
            issue(4'd3, 32'h0000_8000, 32'h0000_8000, 0, "R5 mac chain");
        issue(4'd5, 0, 0, 0, "R5 mid read");
        issue(4'd2, 32'h8000_0000, 32'h7FFF_0000, 0, "R5 mac hi neg");
        issue(4'd6, 0, 0, 0, "R5 low after neg");
        idle(2);
        // R7 loads
        issue(4'd7, 32'hCAFE_F00D, 0, 0, "R7 load hi");
        issue(4'd8, 32'h1357_9BDF, 0, 0, "R7 load lo");
        issue(4'd6, 0, 0, 0, "R7 lo read");
        issue(4'd5, 0, 0, 0, "R6 mid after load");
        // R11 unused code keeps accumulator
        issue(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R11 unused code");
        issue(4'd15, 32'h1, 32'h1, 0, "R11 unused code 15");
        issue(4'd6, 0, 0, 0, "R11 acc kept lo");
        issue(4'd4, 0, 0, 0, "R11 acc kept hi");
        idle(1);
        // R8 rounding without saturation
        issue(4'd7, 32'h0000_0001, 0, 0, "R7 load hi");
        issue(4'd8, 32'h4000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd1, "R8 round by 1");
        issue(4'd6, 0, 0, 0, "R8 low cleared");
        issue(4'd7, 32'h0000_0001, 0, 0, "R7 load hi");
        issue(4'd8, 32'h4000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd2, "R8 round by 2");
        issue(4'd7, 32'hFFFF_FFF0, 0, 0, "R7 load hi");
        issue(4'd8, 32'hC000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd1, "R8 round negative");
        // R9 saturation and exact bound
        issue(4'd7, 32'h0000_7FFF, 0, 0, "R7 load hi");
        issue(4'd8, 32'h8000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd1, "R9 sat high");
        issue(4'd6, 0, 0, 0, "R9 sat low word");
        issue(4'd7, 32'h0000_3FFF, 0, 0, "R7 load hi");
        issue(4'd8, 32'h4000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd1, "R9 exact bound kept");
        issue(4'd7, 32'h0000_3FFF, 0, 0, "R7 load hi");
        issue(4'd8, 32'h8000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd1, "R9 just above bound");
        issue(4'd7, 32'hFFFF_8000, 0, 0, "R7 load hi");
        issue(4'd8, 32'h0000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd1, "R9 sat low");
        issue(4'd7, 32'hFFFF_C000, 0, 0, "R7 load hi");
        issue(4'd8, 32'h0000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd1, "R9 lower bound kept");
        idle(1);
        // R10 shift codes 0 and 3 act as 1
        issue(4'd7, 32'h0000_0123, 0, 0, "R7 load hi");
        issue(4'd8, 32'hC000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd0, "R10 shift code 0");
        issue(4'd7, 32'h0000_0123, 0, 0, "R7 load hi");
        issue(4'd8, 32'hC000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd3, "R10 shift code 3");
        issue(4'd7, 32'h0000_0123, 0, 0, "R7 load hi");
        issue(4'd8, 32'hC000_0000, 0, 0, "R7 load lo");
        issue(4'd9, 0, 0, 2'd2, "R10 shift code 2");
        idle(4);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R2: pending=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule